// File: doc/BRIEF.md
# Four-Element Load-and-Broadcast Unit

This block carries out one vector load that fetches four consecutive memory elements and copies each one into every lane of its own 64-bit destination register. It receives the fields of an already decoded instruction word, the value of the base register and the value of the index register. From these it works out the element size, the four destination register numbers, the alignment the base address must meet and the way the base register is updated afterwards.

A legal request leads to four element reads, one after another, on a simple request/ready memory port with a separate response strobe. When the fourth response has arrived, the four replicated register images, their register numbers and the optional new base value are all presented in a single cycle together with a done pulse. An illegal encoding, an unpredictable register choice or a misaligned base ends the request without any memory traffic. Each of these endings raises a single-cycle flag of its own, and the unit is then idle again.

Top module: `bcast_ld4_unit`

## Requirements
- R1: After reset, `done_o`, `undef_o`, `unpred_o`, `afault_o`, `wb_en_o` and `mem_req_o` are all low.
- R2: The element byte count on `mem_bytes_o` is 1 for size 00, 2 for size 01 and 4 for size 10 or 11.
- R3: Size 11 with `align_i` = 0 is undefined. `undef_o` pulses in the cycle after the start edge, no read is issued and no done follows. This check has priority over R6 and R4.
- R4: The required alignment is 1 byte (no check) when `align_i` = 0 and size is not 11. In every other case it is 4, 8, 8 or 16 bytes for size 00, 01, 10 or 11. If the base is not a multiple of that alignment, `afault_o` pulses in the cycle after the start edge and no read is issued.
- R5: The first destination number is {`dhi_i`,`vd_i`}. Each later destination adds 1 when `spaced_i` = 0 and 2 when `spaced_i` = 1. Destination k appears in `wr_idx_o[5k+4:5k]`.
- R6: If the fourth destination number exceeds 31, or `rn_i` = 15, `unpred_o` pulses in the cycle after the start edge and the request is dropped with no read. R6 has priority over R4.
- R7: The reads go to base, base+e, base+2e and base+3e, where e is the element byte count, in that order. Only one read is outstanding at a time, and address and byte count are held while `mem_req_o` waits for `mem_ready_i`.
- R8: An element is taken from the low e bytes of `mem_rdata_i`, with byte 0 as the least significant byte. It is repeated to fill all 64 bits of destination k in `wr_data_o[64k+63:64k]`. Unused upper response bytes are ignored.
- R9: If `rm_i` = 15, `wb_en_o` stays low. If `rm_i` = 13, `wb_val_o` = base+4e. Any other `rm_i` gives `wb_val_o` = base+`index_i`, with `wb_en_o` high.
- R10: `done_o`, `wr_idx_o`, `wr_data_o` and the writeback are presented together in the cycle after the fourth response is sampled. Exactly one outcome strobe fires per accepted start. A start while busy is ignored.
- R11: Read addresses and the updated base wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| dhi_i | input | 1 | High bit of the first destination number |
| vd_i | input | 4 | Low bits of the first destination number |
| rn_i | input | 4 | Base register number |
| size_i | input | 2 | Element size code |
| spaced_i | input | 1 | Destination spacing select (0: step 1, 1: step 2) |
| align_i | input | 1 | Alignment request bit |
| rm_i | input | 4 | Writeback select / index register number |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| mem_req_o | output | 1 | Read request |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_addr_o | output | 32 | Read byte address |
| mem_bytes_o | output | 3 | Read byte count (1, 2 or 4) |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Load complete; destination and writeback outputs valid |
| wr_idx_o | output | 20 | Four destination register numbers |
| wr_data_o | output | 256 | Four replicated 64-bit register images |
| wb_en_o | output | 1 | Base writeback enable, pulsed with done |
| wb_val_o | output | 32 | Updated base value |
| undef_o | output | 1 | Undefined-encoding strobe |
| unpred_o | output | 1 | Unpredictable-encoding strobe |
| afault_o | output | 1 | Alignment-fault strobe |

## Verification
The undefined, unpredictable and alignment-fault strobes are registered once. They are due in the first cycle after the clock edge that samples `start_i`. `done_o` and its data are due one cycle after the edge that samples the fourth `mem_rvalid_i`. The time between start and done is not fixed, because it depends on how long the memory model stalls `mem_ready_i` and on its response delay of one to three cycles. For that reason the scoreboard does not count cycles for done. It samples every outcome strobe at the falling clock edge, matches it against the next expected item in the queue, and treats any strobe that arrives with an empty queue as a failure. The memory model checks each accepted request address and byte count against a second queue, in issue order.

// File: rtl/bld4_pkg.sv
package bld4_pkg;
   localparam int DST_IDX_W = 5;

   typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} bld4_state_t;
   typedef enum logic [1:0] {WB_NONE, WB_STEP, WB_INDEX} bld4_wb_t;

   function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
      case (sz)
         2'b00:   elem_bytes = 3'd1;
         2'b01:   elem_bytes = 3'd2;
         default: elem_bytes = 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/bld4_decode.sv
module bld4_decode
   import bld4_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int N_DST  = 4
) (
   input  logic                        dhi_i,
   input  logic [3:0]                  vd_i,
   input  logic [3:0]                  rn_i,
   input  logic [3:0]                  rm_i,
   input  logic [1:0]                  size_i,
   input  logic                        spaced_i,
   input  logic                        align_i,
   input  logic [ADDR_W-1:0]           base_i,
   output logic                        undef_o,
   output logic                        unpred_o,
   output logic                        misal_o,
   output logic [2:0]                  ebytes_o,
   output bld4_wb_t                    wbm_o,
   output logic [N_DST*DST_IDX_W-1:0]  dst_o
);
   localparam int SUM_W = DST_IDX_W + $clog2(2 * N_DST) + 1;

   logic [SUM_W-1:0] first_w, step_w, last_w;
   logic [4:0]       amask;
   logic [2:0]       shamt;

   assign first_w = SUM_W'({dhi_i, vd_i});
   assign step_w  = spaced_i ? SUM_W'(2) : SUM_W'(1);
   assign last_w  = first_w + SUM_W'(N_DST - 1) * step_w;

   for (genvar i = 0; i < N_DST; i++) begin : g_dst
      logic [SUM_W-1:0] num;
      assign num = first_w + SUM_W'(i) * step_w;
      assign dst_o[i*DST_IDX_W +: DST_IDX_W] = num[DST_IDX_W-1:0];
   end

   assign undef_o  = (size_i == 2'b11) && !align_i;
   assign unpred_o = (last_w[SUM_W-1:DST_IDX_W] != '0) || (rn_i == 4'hF);
   assign ebytes_o = elem_bytes(size_i);

   assign shamt = {2'b00, size_i[1]} + {2'b00, size_i[0]};
   always_comb begin
      if (!align_i && size_i != 2'b11) amask = 5'd0;
      else                             amask = 5'((6'd4 << shamt) - 6'd1);
   end
   assign misal_o = |(base_i[4:0] & amask);

   always_comb begin
      if (rm_i == 4'hF)      wbm_o = WB_NONE;
      else if (rm_i == 4'hD) wbm_o = WB_STEP;
      else                   wbm_o = WB_INDEX;
   end
endmodule

// File: rtl/bld4_replicate.sv
module bld4_replicate #(
   parameter int DATA_W = 32,
   parameter int REG_W  = 64
) (
   input  logic [1:0]        size_i,
   input  logic [DATA_W-1:0] raw_i,
   output logic [REG_W-1:0]  rep_o
);
   localparam int N_BYTES = REG_W / 8;

   for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
      localparam int H = b % 2;
      localparam int W = b % 4;
      assign rep_o[8*b +: 8] = (size_i == 2'b00) ? raw_i[7:0]     :
                               (size_i == 2'b01) ? raw_i[8*H +: 8] :
                                                   raw_i[8*W +: 8];
   end
endmodule

// File: rtl/bcast_ld4_unit.sv
module bcast_ld4_unit
   import bld4_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int REG_W  = 64,
   parameter int N_DST  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic                        dhi_i,
   input  logic [3:0]                  vd_i,
   input  logic [3:0]                  rn_i,
   input  logic [1:0]                  size_i,
   input  logic                        spaced_i,
   input  logic                        align_i,
   input  logic [3:0]                  rm_i,
   input  logic [ADDR_W-1:0]           base_i,
   input  logic [ADDR_W-1:0]           index_i,
   output logic                        mem_req_o,
   input  logic                        mem_ready_i,
   output logic [ADDR_W-1:0]           mem_addr_o,
   output logic [2:0]                  mem_bytes_o,
   input  logic                        mem_rvalid_i,
   input  logic [DATA_W-1:0]           mem_rdata_i,
   output logic                        done_o,
   output logic [N_DST*DST_IDX_W-1:0]  wr_idx_o,
   output logic [N_DST*REG_W-1:0]      wr_data_o,
   output logic                        wb_en_o,
   output logic [ADDR_W-1:0]           wb_val_o,
   output logic                        undef_o,
   output logic                        unpred_o,
   output logic                        afault_o
);
   localparam int CNT_W = $clog2(N_DST);

   if (DATA_W < 32)        begin : g_bad_data  $error("DATA_W must hold a 4-byte element"); end
   if (REG_W % 32 != 0)    begin : g_bad_reg   $error("REG_W must be a multiple of 32"); end
   if (N_DST < 2)          begin : g_bad_dst   $error("N_DST must be at least 2"); end
   if (ADDR_W < 5)         begin : g_bad_addr  $error("ADDR_W too small for the alignment check"); end

   logic                       undef_c, unpred_c, misal_c;
   logic [2:0]                 eb_c;
   bld4_wb_t                   wbm_c;
   logic [N_DST*DST_IDX_W-1:0] dst_c;
   logic [REG_W-1:0]           rep_c;

   bld4_state_t               st_q;
   logic [CNT_W-1:0]          cnt_q;
   logic [ADDR_W-1:0]         addr_q, base_q, index_q;
   bld4_wb_t                  wbm_q;
   logic [2:0]                eb_q;
   logic [1:0]                size_q;
   logic                      capture;
   logic                      busy;

   bld4_decode #(.ADDR_W(ADDR_W), .N_DST(N_DST)) u_dec (
      .dhi_i(dhi_i), .vd_i(vd_i), .rn_i(rn_i), .rm_i(rm_i), .size_i(size_i),
      .spaced_i(spaced_i), .align_i(align_i), .base_i(base_i),
      .undef_o(undef_c), .unpred_o(unpred_c), .misal_o(misal_c),
      .ebytes_o(eb_c), .wbm_o(wbm_c), .dst_o(dst_c)
   );

   bld4_replicate #(.DATA_W(DATA_W), .REG_W(REG_W)) u_rep (
      .size_i(size_q), .raw_i(mem_rdata_i), .rep_o(rep_c)
   );

   assign capture     = (st_q == S_WAIT) && mem_rvalid_i;
   assign busy        = (st_q != S_IDLE);
   assign mem_req_o   = (st_q == S_REQ);
   assign mem_addr_o  = addr_q;
   assign mem_bytes_o = eb_q;

   for (genvar k = 0; k < N_DST; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                      wr_data_o[k*REG_W +: REG_W] <= '0;
         else if (capture && cnt_q == CNT_W'(k))          wr_data_o[k*REG_W +: REG_W] <= rep_c;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         cnt_q    <= '0;
         addr_q   <= '0;
         base_q   <= '0;
         index_q  <= '0;
         wbm_q    <= WB_NONE;
         eb_q     <= 3'd1;
         size_q   <= 2'b00;
         wr_idx_o <= '0;
         wb_val_o <= '0;
         done_o   <= 1'b0;
         wb_en_o  <= 1'b0;
         undef_o  <= 1'b0;
         unpred_o <= 1'b0;
         afault_o <= 1'b0;
      end else begin
         done_o   <= 1'b0;
         wb_en_o  <= 1'b0;
         undef_o  <= 1'b0;
         unpred_o <= 1'b0;
         afault_o <= 1'b0;
         case (st_q)
            S_IDLE: if (start_i) begin
               if (undef_c)       undef_o  <= 1'b1;
               else if (unpred_c) unpred_o <= 1'b1;
               else if (misal_c)  afault_o <= 1'b1;
               else begin
                  st_q     <= S_REQ;
                  cnt_q    <= '0;
                  addr_q   <= base_i;
                  base_q   <= base_i;
                  index_q  <= index_i;
                  wbm_q    <= wbm_c;
                  eb_q     <= eb_c;
                  size_q   <= size_i;
                  wr_idx_o <= dst_c;
               end
            end
            S_REQ: if (mem_ready_i) st_q <= S_WAIT;
            S_WAIT: if (mem_rvalid_i) begin
               if (cnt_q == CNT_W'(N_DST - 1)) begin
                  st_q    <= S_IDLE;
                  done_o  <= 1'b1;
                  wb_en_o <= (wbm_q != WB_NONE);
                  wb_val_o <= (wbm_q == WB_STEP) ? base_q + ADDR_W'(N_DST) * ADDR_W'(eb_q)
                                                 : base_q + index_q;
               end else begin
                  st_q   <= S_REQ;
                  cnt_q  <= cnt_q + 1'b1;
                  addr_q <= addr_q + ADDR_W'(eb_q);
               end
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bld4_chk.sv
module bld4_chk #(
   parameter int ADDR_W = 32,
   parameter int N_DST  = 4,
   parameter int IDX_W  = 5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start_i,
   input logic [1:0]              size_i,
   input logic                    align_i,
   input logic                    busy,
   input logic                    mem_req_o,
   input logic                    mem_ready_i,
   input logic [ADDR_W-1:0]       mem_addr_o,
   input logic [2:0]              mem_bytes_o,
   input logic                    done_o,
   input logic                    undef_o,
   input logic                    unpred_o,
   input logic                    afault_o,
   input logic [N_DST*IDX_W-1:0]  wr_idx_o
);
   // R10: at most one outcome per cycle
   p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, undef_o, unpred_o, afault_o}));

   // R3: undefined encoding reported in the next cycle
   p_undef_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy && size_i == 2'b11 && !align_i) |=> undef_o);

   // R7: stalled request holds address and count
   p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_bytes_o)));

   // R2: byte count is legal
   p_bytes_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (mem_bytes_o == 3'd1 || mem_bytes_o == 3'd2 || mem_bytes_o == 3'd4));

   // R5: destinations ascend, no wrap past 31
   p_dst_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (wr_idx_o[(N_DST-1)*IDX_W +: IDX_W] > wr_idx_o[IDX_W-1:0]));

   // R6: a rejected request issues no read
   p_reject_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (undef_o || unpred_o || afault_o) |-> !mem_req_o);
endmodule

bind bcast_ld4_unit bld4_chk #(.ADDR_W(ADDR_W), .N_DST(N_DST), .IDX_W(5)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i), .align_i(align_i),
   .busy(busy), .mem_req_o(mem_req_o), .mem_ready_i(mem_ready_i),
   .mem_addr_o(mem_addr_o), .mem_bytes_o(mem_bytes_o), .done_o(done_o),
   .undef_o(undef_o), .unpred_o(unpred_o), .afault_o(afault_o), .wr_idx_o(wr_idx_o)
);

// File: tb/tb_bcast_ld4_unit.sv
module tb_bcast_ld4_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic         start_i = 0, dhi_i = 0, spaced_i = 0, align_i = 0;
   logic [3:0]   vd_i = 0, rn_i = 0, rm_i = 0;
   logic [1:0]   size_i = 0;
   logic [31:0]  base_i = 0, index_i = 0;
   logic         mem_req_o, mem_ready_i = 0, mem_rvalid_i = 0;
   logic [31:0]  mem_addr_o, mem_rdata_i = 0;
   logic [2:0]   mem_bytes_o;
   logic         done_o, wb_en_o, undef_o, unpred_o, afault_o;
   logic [19:0]  wr_idx_o;
   logic [255:0] wr_data_o;
   logic [31:0]  wb_val_o;

   bcast_ld4_unit dut (.*);

   int tests = 0, fails = 0, seen = 0, cyc = 0, nreq = 0;
   bit finished = 0;

   typedef struct {
      int           kind;
      string        req;
      logic [19:0]  idx;
      logic [255:0] data;
      logic         wben;
      logic [31:0]  wbval;
   } exp_t;
   exp_t sbq[$];
   logic [31:0] addrq[$];
   logic [2:0]  bytesq[$];

   function automatic logic [7:0] mb(input logic [31:0] a);
      return a[7:0] ^ {a[11:8], a[3:0]} ^ 8'h3C ^ a[23:16] ^ {a[31:28], a[27:24]};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [255:0] act, input logic [255:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) cyc++;

   // memory model
   initial begin
      int dly = 0;
      bit pend = 0;
      logic [31:0] ra; logic [2:0] rb;
      forever begin
         @(negedge clk);
         mem_rvalid_i = 0;
         if (pend) begin
            dly--;
            if (dly == 0) begin
               pend = 0;
               mem_rvalid_i = 1;
               for (int j = 0; j < 4; j++)
                  mem_rdata_i[8*j +: 8] = (j < rb) ? mb(ra + 32'(j)) : 8'hE7;
            end
         end
         mem_ready_i = (cyc % 5) != 2;
         if (mem_req_o && mem_ready_i) begin
            ra = mem_addr_o; rb = mem_bytes_o;
            if (addrq.size() == 0)
               check(0, "R7", "unexpected read", 256'(ra), 0);
            else begin
               logic [31:0] ea; logic [2:0] eb;
               ea = addrq.pop_front(); eb = bytesq.pop_front();
               check(ra == ea, "R7", "read address", 256'(ra), 256'(ea));
               check(rb == eb, "R2", "byte count", 256'(rb), 256'(eb));
            end
            pend = 1; dly = 1 + (nreq % 3); nreq++;
         end
      end
   end

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         if (done_o || undef_o || unpred_o || afault_o) begin
            int k;
            k = done_o ? 0 : undef_o ? 1 : unpred_o ? 2 : 3;
            if (sbq.size() == 0)
               check(0, "R10", "unexpected outcome", 256'(k), 0);
            else begin
               exp_t e;
               e = sbq.pop_front();
               check(k == e.kind, e.req, "outcome kind", 256'(k), 256'(e.kind));
               if (k == 0 && e.kind == 0) begin
                  check(wr_idx_o == e.idx, "R5", "dest numbers", 256'(wr_idx_o), 256'(e.idx));
                  check(wr_data_o == e.data, "R8", "replicated data", wr_data_o, e.data);
                  check(wb_en_o == e.wben, "R9", "wb enable", 256'(wb_en_o), 256'(e.wben));
                  if (e.wben)
                     check(wb_val_o == e.wbval, e.req, "wb value", 256'(wb_val_o), 256'(e.wbval));
               end
            end
            seen++;
         end
      end
   end

   task automatic issue(input string req, input logic d, input logic [3:0] vd,
                        input logic [3:0] rn, input logic [1:0] sz, input logic t,
                        input logic a, input logic [3:0] rm, input logic [31:0] base,
                        input logic [31:0] idx, input bit poke);
      exp_t e;
      int eb, first, inc, target;
      logic [31:0] mask;
      eb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      first = {27'd0, d, vd};
      inc = t ? 2 : 1;
      mask = (!a && sz != 3) ? 32'd0 : (32'd4 << (int'(sz[1]) + int'(sz[0]))) - 32'd1;
      e.req = req; e.idx = '0; e.data = '0; e.wben = 0; e.wbval = '0;
      if (sz == 3 && !a) e.kind = 1;
      else if (first + 3 * inc > 31 || rn == 15) e.kind = 2;
      else if ((base & mask) != 0) e.kind = 3;
      else begin
         e.kind = 0;
         for (int i = 0; i < 4; i++) begin
            logic [31:0] ad; logic [31:0] el;
            ad = base + 32'(i * eb);
            addrq.push_back(ad); bytesq.push_back(3'(eb));
            el = '0;
            for (int j = 0; j < eb; j++) el[8*j +: 8] = mb(ad + 32'(j));
            for (int b = 0; b < 8; b++)
               e.data[64*i + 8*b +: 8] = el[8*(b % eb) +: 8];
            e.idx[5*i +: 5] = 5'(first + i * inc);
         end
         e.wben = (rm != 15);
         e.wbval = (rm == 13) ? base + 32'(4 * eb) : base + idx;
      end
      sbq.push_back(e);
      target = seen + 1;
      @(negedge clk);
      start_i = 1; dhi_i = d; vd_i = vd; rn_i = rn; size_i = sz; spaced_i = t;
      align_i = a; rm_i = rm; base_i = base; index_i = idx;
      @(negedge clk);
      start_i = 0;
      if (poke) begin
         @(negedge clk);
         // R10: start while busy, with an undefined encoding, must be ignored
         start_i = 1; size_i = 2'b11; align_i = 0; base_i = 32'h0;
         @(negedge clk);
         start_i = 0;
      end
      wait (seen >= target);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!done_o && !undef_o && !unpred_o && !afault_o && !wb_en_o && !mem_req_o,
            "R1", "reset outputs", 256'({done_o, undef_o, unpred_o, afault_o, wb_en_o, mem_req_o}), 0);
      rst_n = 1;
      @(negedge clk);
      // R2/R7/R8/R9 byte elements, no check, no writeback
      issue("R9", 0, 4'd2, 4'd1, 2'b00, 0, 0, 4'hF, 32'h0000_1003, 32'h0, 0);
      // halfwords, aligned 8, spaced, step writeback
      issue("R9", 1, 4'd0, 4'd2, 2'b01, 1, 1, 4'hD, 32'h0000_2008, 32'h0, 0);
      // words, aligned 8, index writeback
      issue("R9", 0, 4'd5, 4'd3, 2'b10, 0, 1, 4'd4, 32'h0000_3008, 32'h100, 0);
      // size 11 aligned 16, step writeback
      issue("R9", 0, 4'd8, 4'd0, 2'b11, 1, 1, 4'hD, 32'h0000_4010, 32'h0, 0);
      // R3 undefined, also with Rn 15 to show priority
      issue("R3", 0, 4'd0, 4'd1, 2'b11, 0, 0, 4'hF, 32'h0000_4010, 32'h0, 0);
      issue("R3", 1, 4'd15, 4'hF, 2'b11, 1, 0, 4'hF, 32'h0000_4011, 32'h0, 0);
      // R6 last destination past 31, and Rn 15; priority over misalignment
      issue("R6", 1, 4'd13, 4'd1, 2'b00, 1, 0, 4'hF, 32'h0, 32'h0, 0);
      issue("R6", 0, 4'd0, 4'hF, 2'b01, 0, 1, 4'hF, 32'h0000_2001, 32'h0, 0);
      // R5 boundary: last destination exactly 31
      issue("R5", 1, 4'd12, 4'd1, 2'b01, 0, 0, 4'hF, 32'h0000_5555, 32'h0, 0);
      // R4 alignment faults for each size
      issue("R4", 0, 4'd0, 4'd1, 2'b00, 0, 1, 4'hF, 32'h0000_1002, 32'h0, 0);
      issue("R4", 0, 4'd0, 4'd1, 2'b01, 0, 1, 4'hF, 32'h0000_2004, 32'h0, 0);
      issue("R4", 0, 4'd0, 4'd1, 2'b10, 0, 1, 4'hF, 32'h0000_3004, 32'h0, 0);
      issue("R4", 0, 4'd0, 4'd1, 2'b11, 0, 1, 4'hF, 32'h0000_4008, 32'h0, 0);
      // R4 no check when align bit is 0
      issue("R4", 0, 4'd3, 4'd1, 2'b10, 0, 0, 4'd7, 32'h0000_3001, 32'h10, 0);
      // R11 wrap of addresses and of base update
      issue("R11", 0, 4'd1, 4'd2, 2'b01, 0, 0, 4'hD, 32'hFFFF_FFFE, 32'h0, 0);
      issue("R11", 0, 4'd1, 4'd2, 2'b00, 1, 0, 4'd2, 32'hFFFF_FFF0, 32'h20, 0);
      // R10 start while busy ignored
      issue("R10", 0, 4'd4, 4'd6, 2'b10, 0, 1, 4'd9, 32'h0000_6008, 32'h4, 1);
      repeat (10) @(negedge clk);
      check(sbq.size() == 0 && addrq.size() == 0, "R10", "leftover items",
            256'(sbq.size() + addrq.size()), 0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule